// File: doc/BRIEF.md
# Character LCD nibble-mode controller

This block is a hardware sequencer for a character LCD wired with only the upper four data lines, plus enable, register select and read/write. After reset it brings the display up on its own. First come four single-nibble commands, each spaced by a programmable idle delay. Then come four full configuration bytes. Only then does it tell its user that it can take work.

Each request is one byte, flagged as a command or as display data, and handed over on a valid/ready handshake. The byte goes to the display as two nibble writes, upper half first. Before every full byte, the controller polls the display's busy flag. A poll is a pair of status-read nibbles, and the pairs repeat until the flag comes back clear. The enable pulse has a fixed, parameterised width. Register select, read/write and the write data are framed around that pulse with one clock of margin on each side.

Cursor placement is done with ordinary command bytes. For example, 0x80 moves to the start of the first line (address 0x00) and 0xC0 to the start of the second line (address 0x40).

Top module: `lcd_nib_ctrl`

## Requirements
- R1: While reset is held and in the first clock after it is released, lcd_e is low and req_ready is low.
- R2: After reset, four single-nibble command writes (lcd_rs=0, lcd_rw=0) go out with lcd_dout values 0x3, 0x3, 0x3 and then 0x2. Each is preceded by at least INIT_DELAY clocks with lcd_e low, and no status read comes before any of them.
- R3: After the preamble, the command bytes 0x28, 0x08, 0x01 and 0x06 are sent in that order as full bytes. Each is preceded by busy polling.
- R4: A full byte is sent as two write nibbles on lcd_dout, bits 7..4 first and bits 3..0 second. During every write pulse lcd_oe is 1 and lcd_rw is 0.
- R5: lcd_rs is 0 for command writes and for status reads, and 1 for data writes (req_is_data=1). lcd_rw is 1 only during status reads.
- R6: Before each full byte, status is read as two nibbles (lcd_rw=1, lcd_rs=0, lcd_oe=0). The busy flag is lcd_d7_in sampled in the first nibble only. The value in the second nibble is ignored. The pair repeats until the flag reads 0.
- R7: Every enable pulse is high for exactly E_CYCLES clocks.
- R8: lcd_rs, lcd_rw and lcd_dout are unchanged in the clock before lcd_e rises and in the clock after it falls.
- R9: req_ready is high only when initialisation and any transfer are finished. A byte is accepted on a clock where req_valid and req_ready are both 1, and it is the one sent next.
- R10: req_ready is low while a transfer or poll is in progress. A req_valid pulse while req_ready is low sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A byte request is offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_is_data | input | 1 | 1 = display data, 0 = command |
| req_byte | input | 8 | Byte to send |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Register select (0 command/status, 1 data) |
| lcd_rw | output | 1 | 1 = read status, 0 = write |
| lcd_oe | output | 1 | 1 while the controller drives the data lines |
| lcd_dout | output | 4 | Nibble driven onto data lines D7..D4 |
| lcd_d7_in | input | 1 | Data line D7 as read back from the display |

## Verification
The built-in properties assume that lcd_d7_in is stable for the whole of each status-read enable pulse. The bench's display model meets this by choosing the line level at the rising edge of enable and holding it until the next pulse. The properties also assume that the requester treats req_ready as a plain level and changes its request fields only between clock edges. The bench does this by driving the request fields on falling clock edges only. It also drives req_valid while ready is low, to show that such a request is dropped rather than relying on the requester to avoid it.

// File: rtl/lcd_nib_ctrl.sv
module lcd_nib_ctrl #(
  parameter int E_CYCLES   = 12,
  parameter int INIT_DELAY = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       lcd_e,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_oe,
  output logic [3:0] lcd_dout,
  input  logic       lcd_d7_in
);

  localparam int TW = $clog2(E_CYCLES + 1);
  localparam int DW = $clog2(INIT_DELAY + 1);

  typedef enum logic [2:0] {
    ST_DELAY, ST_PRE, ST_POLL_H, ST_POLL_L, ST_WR_H, ST_WR_L, ST_IDLE
  } st_t;
  typedef enum logic [1:0] {PH_SET, PH_EN, PH_HOLD} ph_t;

  st_t           st;
  ph_t           ph;
  logic [TW-1:0] tcnt;
  logic [DW-1:0] dcnt;
  logic [1:0]    pre_cnt;
  logic [1:0]    init_idx;
  logic          init_done;
  logic [7:0]    cur_byte;
  logic          cur_rs;
  logic          busy_flag;

  function automatic logic [7:0] init_cmd(input logic [1:0] i);
    case (i)
      2'd0:    init_cmd = 8'h28;
      2'd1:    init_cmd = 8'h08;
      2'd2:    init_cmd = 8'h01;
      default: init_cmd = 8'h06;
    endcase
  endfunction

  wire in_nib   = (st == ST_PRE) || (st == ST_POLL_H) || (st == ST_POLL_L) ||
                  (st == ST_WR_H) || (st == ST_WR_L);
  wire en_last  = (ph == PH_EN) && (tcnt == TW'(E_CYCLES - 1));
  wire nib_done = in_nib && (ph == PH_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_DELAY;
      ph        <= PH_SET;
      tcnt      <= '0;
      dcnt      <= '0;
      pre_cnt   <= '0;
      init_idx  <= '0;
      init_done <= 1'b0;
      cur_byte  <= '0;
      cur_rs    <= 1'b0;
      busy_flag <= 1'b0;
    end else begin
      if (in_nib) begin
        case (ph)
          PH_SET: begin
            ph   <= PH_EN;
            tcnt <= '0;
          end
          PH_EN: begin
            if (en_last) ph <= PH_HOLD;
            else         tcnt <= tcnt + 1'b1;
          end
          default: ph <= PH_SET;
        endcase
      end
      if (st == ST_POLL_H && en_last) busy_flag <= lcd_d7_in;
      case (st)
        ST_DELAY: begin
          if (dcnt == DW'(INIT_DELAY - 1)) begin
            dcnt <= '0;
            st   <= ST_PRE;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_PRE: if (nib_done) begin
          pre_cnt <= pre_cnt + 2'd1;
          if (pre_cnt == 2'd3) begin
            cur_byte <= init_cmd(2'd0);
            cur_rs   <= 1'b0;
            st       <= ST_POLL_H;
          end else begin
            st <= ST_DELAY;
          end
        end
        ST_POLL_H: if (nib_done) st <= ST_POLL_L;
        ST_POLL_L: if (nib_done) st <= busy_flag ? ST_POLL_H : ST_WR_H;
        ST_WR_H:   if (nib_done) st <= ST_WR_L;
        ST_WR_L: if (nib_done) begin
          if (init_done) begin
            st <= ST_IDLE;
          end else if (init_idx == 2'd3) begin
            init_done <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            init_idx <= init_idx + 2'd1;
            cur_byte <= init_cmd(init_idx + 2'd1);
            st       <= ST_POLL_H;
          end
        end
        ST_IDLE: if (req_valid) begin
          cur_byte <= req_byte;
          cur_rs   <= req_is_data;
          st       <= ST_POLL_H;
        end
        default: st <= ST_DELAY;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign lcd_e     = in_nib && (ph == PH_EN);
  assign lcd_rw    = (st == ST_POLL_H) || (st == ST_POLL_L);
  assign lcd_rs    = ((st == ST_WR_H) || (st == ST_WR_L)) && cur_rs;
  assign lcd_oe    = (st == ST_PRE) || (st == ST_WR_H) || (st == ST_WR_L);
  assign lcd_dout  = (st == ST_PRE)  ? ((pre_cnt == 2'd3) ? 4'h2 : 4'h3) :
                     (st == ST_WR_H) ? cur_byte[7:4] :
                     (st == ST_WR_L) ? cur_byte[3:0] : 4'h0;

  logic [TW:0] e_run;
  always_ff @(posedge clk) begin
    if (!rst_n) e_run <= '0;
    else        e_run <= lcd_e ? e_run + 1'b1 : '0;
  end

  AST_E_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> e_run == (TW+1)'(E_CYCLES)); // R7
  AST_E_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout)); // R8
  AST_E_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout)); // R8
  AST_READ_RS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !lcd_rs); // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> (lcd_oe != lcd_rw)); // R4
  AST_NO_READY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready); // R10

endmodule

// File: tb/lcd_nib_ctrl_bench.sv
module lcd_nib_ctrl_bench;
  localparam int EC = 3;
  localparam int ID = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid = 1'b0, req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready, lcd_e, lcd_rs, lcd_rw, lcd_oe;
  logic [3:0] lcd_dout;
  logic       lcd_d7_in = 1'b0;

  lcd_nib_ctrl #(.E_CYCLES(EC), .INIT_DELAY(ID)) u_lcd_nib_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .lcd_e(lcd_e),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_oe(lcd_oe), .lcd_dout(lcd_dout),
    .lcd_d7_in(lcd_d7_in));

  int total = 0, bad = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  int         busy_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push(input logic [5:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // expected stream entry: {rw, rs, nibble}
  task automatic expect_byte(input logic rs, input logic [7:0] b, input int nb,
                             input string tag);
    busy_q.push_back(nb);
    for (int k = 0; k < 2 * (nb + 1); k++) push({1'b1, 1'b0, 4'h0}, "R6");
    push({1'b0, rs, b[7:4]}, tag);
    push({1'b0, rs, b[3:0]}, tag);
  endtask

  task automatic send(input logic is_data, input logic [7:0] b, input int nb);
    expect_byte(is_data, b, nb, is_data ? "R5" : "R4");
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    req_is_data = is_data;
    req_byte    = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!req_ready && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req_ready, tag, "ready returns", int'(req_ready), 1);
  endtask

  // monitor and display model
  int   cyc = 0, hi_cnt = 0, lo_cnt = 0, ev_idx = 0, busy_left = 0;
  bit   prv_e = 0, prv_rs = 0, prv_rw = 0, new_byte = 1, rd_ph = 0;
  logic [3:0] prv_d = 4'h0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R9", "watchdog expired", cyc, 150000);
      finish_up();
    end
    if (!rst_n) begin
      prv_e = 0; lo_cnt = 0; hi_cnt = 0;
    end else begin
      if (!prv_e && lcd_e) begin
        chk(lcd_rs == prv_rs && lcd_rw == prv_rw && lcd_dout == prv_d, "R8",
            "setup before enable", {lcd_rw, lcd_rs, lcd_dout}, {prv_rw, prv_rs, prv_d});
        if (!lcd_rw && ev_idx < 4)
          chk(lo_cnt >= ID, "R2", "idle clocks before preamble write", lo_cnt, ID);
        if (lcd_rw) begin
          if (!rd_ph) begin
            if (new_byte) begin
              busy_left = (busy_q.size() > 0) ? busy_q.pop_front() : 0;
              new_byte  = 0;
            end
            lcd_d7_in = (busy_left > 0);
          end else begin
            lcd_d7_in = 1'b1;
          end
        end
        hi_cnt = 1;
        lo_cnt = 0;
      end else if (prv_e && !lcd_e) begin
        chk(hi_cnt == EC, "R7", "enable width", hi_cnt, EC);
        chk(lcd_rs == prv_rs && lcd_rw == prv_rw && lcd_dout == prv_d, "R8",
            "hold after enable", {lcd_rw, lcd_rs, lcd_dout}, {prv_rw, prv_rs, prv_d});
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected nibble", {lcd_rw, lcd_rs, lcd_dout}, 0);
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(lcd_rw == e[5] && lcd_rs == e[4], t, "rw/rs", {lcd_rw, lcd_rs}, e[5:4]);
          if (!e[5]) chk(lcd_dout == e[3:0] && lcd_oe, t, "write nibble",
                         {lcd_oe, lcd_dout}, {1'b1, e[3:0]});
          else       chk(!lcd_oe, "R6", "bus released on read", int'(lcd_oe), 0);
        end
        if (lcd_rw) begin
          if (!rd_ph) rd_ph = 1;
          else begin
            rd_ph = 0;
            if (busy_left > 0) busy_left--;
          end
        end else begin
          new_byte = 1;
        end
        ev_idx++;
        hi_cnt = 0;
        lo_cnt = 1;
      end else if (lcd_e) hi_cnt++;
      else lo_cnt++;
      prv_e = lcd_e; prv_rs = lcd_rs; prv_rw = lcd_rw; prv_d = lcd_dout;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!lcd_e, "R1", "enable in reset", int'(lcd_e), 0);
    chk(!req_ready, "R1", "ready in reset", int'(req_ready), 0);
    for (int k = 0; k < 3; k++) push({1'b0, 1'b0, 4'h3}, "R2");
    push({1'b0, 1'b0, 4'h2}, "R2");
    expect_byte(1'b0, 8'h28, 0, "R3");
    expect_byte(1'b0, 8'h08, 1, "R3");
    expect_byte(1'b0, 8'h01, 0, "R3");
    expect_byte(1'b0, 8'h06, 2, "R3");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1", "ready right after reset", int'(req_ready), 0);
    chk(!lcd_e, "R1", "enable right after reset", int'(lcd_e), 0);
    wait_ready("R3");
    chk(exp_q.size() == 0, "R3", "init stream finished", exp_q.size(), 0);
    chk(req_ready, "R9", "ready after init", int'(req_ready), 1);

    send(1'b0, 8'h80, 0);
    send(1'b1, 8'h41, 1);
    send(1'b1, 8'h7E, 0);
    send(1'b0, 8'hC0, 3);
    // R10: offer a byte while busy; it must not appear on the display bus
    for (int k = 0; k < 5; k++) begin
      req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'hEE;
      @(negedge clk);
      chk(!req_ready, "R10", "ready low while busy", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    send(1'b1, 8'h00, 0);
    send(1'b1, 8'hFF, 2);
    send(1'b1, 8'hA5, 1);
    wait_ready("R9");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all queued nibbles seen", exp_q.size(), 0);
    chk(!lcd_e, "R10", "bus quiet when idle", int'(lcd_e), 0);
    finish_up();
  end
endmodule